// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits on the processor side of the interrupt path. An arbiter upstream has already chosen the request and checked its level against the mask. The sequencer waits for the processor to reach the gap between two instructions before it takes that request. It copies the live status word and program counter into a pair of shadow save registers and acknowledges the arbiter. It then hands the fetch unit a new status word and a new fetch address. The new status word has the block bit and the register-bank bit set. The new fetch address is the vector base plus a fixed handler offset, and it is taken at once, with no delay slot.

The return strobe reverses the entry. In the same cycle it drives the saved status word and saved program counter back out. Since the block bit was clear when the status word was saved, the restored word clears it again. While the live status word carries the block bit, new requests are left pending. The datapath owns the real status and PC registers and loads them whenever `load` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq_ack` and `load` are 0 (with `rte_req` low), and `saved_sr` and `saved_pc` read 0.
- R2: A request is accepted at a clock edge only when the sequencer is idle and, in that cycle, `irq_req`=1, `insn_done`=1, `rte_req`=0 and bit 28 (block) of `cur_sr` is 0. No other input pattern leads to `irq_ack`.
- R3: After an acceptance edge, `irq_ack` is high for exactly one cycle. That cycle is the save state.
- R4: `saved_sr` and `saved_pc` take the `cur_sr` and `cur_pc` values present in the cycle of acceptance. They keep those values until the next acceptance.
- R5: In the cycle right after the save state, `load`=1 and `next_pc` = `vbr` + 0x600, modulo 2^32. The sequencer then returns to idle.
- R6: In that redirect cycle, `next_sr` equals `saved_sr` with bit 28 (block) and bit 29 (register bank) forced to 1. Every other bit is unchanged, including the 4-bit mask field at bits 7:4.
- R7: While bit 28 of `cur_sr` is 1, an idle sequencer ignores `irq_req`.
- R8: When idle, `rte_req`=1 makes `load`=1 in the same cycle, with `next_pc`=`saved_pc` and `next_sr`=`saved_sr`.
- R9: If `rte_req` and an otherwise acceptable request arrive in the same idle cycle, the return is served and the request is not accepted.
- R10: `rte_req` has no effect in the save or redirect state. `load` is 0 in the save state, and the redirect cycle carries the entry values.
- R11: A request without `insn_done` is not taken. Once `insn_done` arrives while the request is still held, the request is accepted.
- R12: When `load` is 0, `next_pc` and `next_sr` are driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Accepted-level request from the arbiter |
| insn_done | input | 1 | High in a cycle that ends an instruction |
| rte_req | input | 1 | Return-from-handler strobe |
| cur_sr | input | 32 | Live status word |
| cur_pc | input | 32 | Live program counter |
| vbr | input | 32 | Vector base |
| irq_ack | output | 1 | Acknowledge to the arbiter, high in the save state |
| load | output | 1 | Datapath must load `next_pc` and `next_sr` |
| next_pc | output | 32 | New fetch address |
| next_sr | output | 32 | New status word |
| saved_sr | output | 32 | Shadow status register |
| saved_pc | output | 32 | Shadow PC register |

## Verification
Two things can land in the same idle cycle: a return strobe and a request that would otherwise be accepted. The bench forces this coincidence in a directed case. It also lets it happen freely under random stimulus, with the return strobe at a moderate rate. It judges the outcome in two ways. In that cycle, `load` must carry the saved values. In the next cycle, `irq_ack` must stay low. A second coincidence is a return strobe that arrives in the middle of an entry. This case is judged by checking that the save state shows no load and that the redirect cycle still carries the handler address.

// File: rtl/ies_pkg.sv
// Package: shared state encoding for the interrupt entry sequencer.
// Assumes: nothing beyond the three sequencer phases.
package ies_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAVE  = 2'd1,
        ST_REDIR = 2'd2
    } ies_state_t;
endpackage

// File: rtl/ies_ctrl.sv
// Module: ies_ctrl
// Control FSM. Decides when a request is taken and steps the
// sequence idle -> save -> redirect. Also flags a return served in idle.
// Assumes: irq_req has already passed priority and mask checks upstream.
module ies_ctrl
    import ies_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       insn_done,
    input  logic       blocked,
    input  logic       rte_req,
    output ies_state_t state,
    output logic       capture,
    output logic       in_save,
    output logic       in_redir,
    output logic       restore
);
    ies_state_t state_nx;

    // Purpose: the return strobe has priority over entry while idle.
    always_comb begin
        restore = (state == ST_IDLE) && rte_req;
        capture = (state == ST_IDLE) && irq_req && insn_done
                  && !blocked && !rte_req;
        in_save  = (state == ST_SAVE);
        in_redir = (state == ST_REDIR);
    end

    // Purpose: next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (capture) state_nx = ST_SAVE;
            ST_SAVE:  state_nx = ST_REDIR;
            ST_REDIR: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/ies_shadow.sv
// Module: ies_shadow
// Shadow save registers for the status word and program counter.
// They load on the acceptance edge and hold until the next one.
// Assumes: capture is high for a single cycle per entry.
module ies_shadow #(
    parameter int SR_W = 32,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [SR_W-1:0] cur_sr,
    input  logic [PC_W-1:0] cur_pc,
    output logic [SR_W-1:0] saved_sr,
    output logic [PC_W-1:0] saved_pc
);
    // Purpose: latch the live state when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_sr <= '0;
            saved_pc <= '0;
        end else if (capture) begin
            saved_sr <= cur_sr;
            saved_pc <= cur_pc;
        end
    end
endmodule

// File: rtl/ies_target.sv
// Module: ies_target
// Forms the status word and fetch address given to the datapath,
// either for the handler redirect or for the return.
// Assumes: redirect and restore are never high together.
module ies_target #(
    parameter int                 SR_W        = 32,
    parameter int                 PC_W        = 32,
    parameter int                 BL_POS      = 28,
    parameter int                 RB_POS      = 29,
    parameter logic [PC_W-1:0]    HANDLER_OFS = 'h600
) (
    input  logic            redirect,
    input  logic            restore,
    input  logic [PC_W-1:0] vbr,
    input  logic [SR_W-1:0] saved_sr,
    input  logic [PC_W-1:0] saved_pc,
    output logic            load,
    output logic [PC_W-1:0] next_pc,
    output logic [SR_W-1:0] next_sr
);
    logic [SR_W-1:0] entry_sr;

    // Entry status word: force the block and bank bits, pass all others.
    for (genvar i = 0; i < SR_W; i++) begin : g_entry_bit
        if (i == BL_POS || i == RB_POS) begin : g_force
            assign entry_sr[i] = 1'b1;
        end else begin : g_pass
            assign entry_sr[i] = saved_sr[i];
        end
    end

    // Purpose: select the redirect or return values, zero when idle.
    always_comb begin
        load    = redirect || restore;
        next_pc = '0;
        next_sr = '0;
        if (redirect) begin
            next_pc = vbr + HANDLER_OFS;
            next_sr = entry_sr;
        end else if (restore) begin
            next_pc = saved_pc;
            next_sr = saved_sr;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Takes an accepted interrupt at an instruction boundary, saves state,
// sets block and bank bits and jumps to vbr + fixed offset.
// Also serves the return strobe.
// Assumes: the datapath loads next_pc/next_sr whenever load is high.
module irq_entry_seq #(
    parameter int              SR_W        = 32,
    parameter int              PC_W        = 32,
    parameter int              BL_POS      = 28,
    parameter int              RB_POS      = 29,
    parameter logic [PC_W-1:0] HANDLER_OFS = 'h600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            insn_done,
    input  logic            rte_req,
    input  logic [SR_W-1:0] cur_sr,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] vbr,
    output logic            irq_ack,
    output logic            load,
    output logic [PC_W-1:0] next_pc,
    output logic [SR_W-1:0] next_sr,
    output logic [SR_W-1:0] saved_sr,
    output logic [PC_W-1:0] saved_pc
);
    import ies_pkg::*;

    ies_state_t state;
    logic       capture;
    logic       in_save;
    logic       in_redir;
    logic       restore;
    logic       blocked;

    // Purpose: the block bit of the live status word holds off new entries.
    assign blocked = cur_sr[BL_POS];
    assign irq_ack = in_save;

    ies_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .insn_done(insn_done),
        .blocked  (blocked),
        .rte_req  (rte_req),
        .state    (state),
        .capture  (capture),
        .in_save  (in_save),
        .in_redir (in_redir),
        .restore  (restore)
    );

    ies_shadow #(.SR_W(SR_W), .PC_W(PC_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .cur_sr  (cur_sr),
        .cur_pc  (cur_pc),
        .saved_sr(saved_sr),
        .saved_pc(saved_pc)
    );

    ies_target #(
        .SR_W(SR_W), .PC_W(PC_W), .BL_POS(BL_POS), .RB_POS(RB_POS),
        .HANDLER_OFS(HANDLER_OFS)
    ) u_target (
        .redirect(in_redir),
        .restore (restore),
        .vbr     (vbr),
        .saved_sr(saved_sr),
        .saved_pc(saved_pc),
        .load    (load),
        .next_pc (next_pc),
        .next_sr (next_sr)
    );
endmodule

// File: rtl/ies_checker.sv
// Module: ies_checker
// Port-level temporal checks of the sequencer, bound to the top module.
// Assumes: the same parameters as the top it is bound to.
module ies_checker #(
    parameter int              SR_W        = 32,
    parameter int              PC_W        = 32,
    parameter int              BL_POS      = 28,
    parameter int              RB_POS      = 29,
    parameter logic [PC_W-1:0] HANDLER_OFS = 'h600
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic            insn_done,
    input logic            rte_req,
    input logic [SR_W-1:0] cur_sr,
    input logic [PC_W-1:0] cur_pc,
    input logic [PC_W-1:0] vbr,
    input logic            irq_ack,
    input logic            load,
    input logic [PC_W-1:0] next_pc,
    input logic [SR_W-1:0] next_sr,
    input logic [SR_W-1:0] saved_sr,
    input logic [PC_W-1:0] saved_pc
);
    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    a_r2_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && $past(rst_n)) |-> $past(irq_req && insn_done && !rte_req && !cur_sr[BL_POS]));

    a_r4_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && $past(rst_n)) |-> (saved_sr == $past(cur_sr) && saved_pc == $past(cur_pc)));

    a_r5_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (load && next_pc == vbr + HANDLER_OFS));

    a_r6_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (next_sr[BL_POS] && next_sr[RB_POS] && next_sr[7:4] == saved_sr[7:4]));

    a_r7_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !load && cur_sr[BL_POS]) |=> !irq_ack);

    a_r8_return_values: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !irq_ack && !$past(irq_ack)) |->
            (load && next_pc == saved_pc && next_sr == saved_sr));

    a_r9_return_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && irq_req && insn_done && !irq_ack && !$past(irq_ack)) |=> !irq_ack);

    a_r10_no_load_in_save: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !load);
endmodule

bind irq_entry_seq ies_checker #(
    .SR_W(SR_W), .PC_W(PC_W), .BL_POS(BL_POS), .RB_POS(RB_POS),
    .HANDLER_OFS(HANDLER_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
    .rte_req(rte_req), .cur_sr(cur_sr), .cur_pc(cur_pc), .vbr(vbr),
    .irq_ack(irq_ack), .load(load), .next_pc(next_pc), .next_sr(next_sr),
    .saved_sr(saved_sr), .saved_pc(saved_pc)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_req = 1'b0, insn_done = 1'b0, rte_req = 1'b0;
    logic [W-1:0] cur_sr = '0, cur_pc = '0, vbr = '0;
    logic         irq_ack, load;
    logic [W-1:0] next_pc, next_sr, saved_sr, saved_pc;

    int total = 0;
    int bad   = 0;

    // bench model: 0 idle, 1 save, 2 redirect
    int           m_st = 0;
    logic [W-1:0] m_ssr = '0, m_spc = '0;

    always #5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
        .rte_req(rte_req), .cur_sr(cur_sr), .cur_pc(cur_pc), .vbr(vbr),
        .irq_ack(irq_ack), .load(load), .next_pc(next_pc), .next_sr(next_sr),
        .saved_sr(saved_sr), .saved_pc(saved_pc)
    );

    function automatic logic [W-1:0] entry_word(logic [W-1:0] s);
        return s | (32'h1 << 28) | (32'h1 << 29);
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // drive one cycle at the falling edge, check, then advance the model
    task automatic step(string tag, logic irq, logic done, logic rte,
                        logic [W-1:0] sr, logic [W-1:0] pc, logic [W-1:0] vb);
        logic         e_ack, e_load;
        logic [W-1:0] e_pc, e_sr;
        @(negedge clk);
        irq_req = irq; insn_done = done; rte_req = rte;
        cur_sr = sr; cur_pc = pc; vbr = vb;
        #1;
        e_ack  = (m_st == 1);
        e_load = (m_st == 2) || (m_st == 0 && rte);
        e_pc = '0; e_sr = '0;
        if (m_st == 2) begin e_pc = vb + 32'h600; e_sr = entry_word(m_ssr); end
        else if (m_st == 0 && rte) begin e_pc = m_spc; e_sr = m_ssr; end
        chk(tag, "irq_ack", {31'b0, irq_ack}, {31'b0, e_ack});
        chk(tag, "load", {31'b0, load}, {31'b0, e_load});
        chk(tag, "next_pc", next_pc, e_pc);
        chk(tag, "next_sr", next_sr, e_sr);
        chk("R4", "saved_sr", saved_sr, m_ssr);
        chk("R4", "saved_pc", saved_pc, m_spc);
        case (m_st)
            0: if (!rte && irq && done && !sr[28]) begin
                   m_st = 1; m_ssr = sr; m_spc = pc;
               end
            1: m_st = 2;
            default: m_st = 0;
        endcase
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: outputs while reset is held
        chk("R1", "irq_ack", {31'b0, irq_ack}, 32'h0);
        chk("R1", "load", {31'b0, load}, 32'h0);
        chk("R1", "saved_sr", saved_sr, 32'h0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 32'h0, 32'h0, 32'h0);

        // R11: request without boundary waits, then is taken
        step("R11", 1, 0, 0, 32'h0000_00A0, 32'h1000, 32'h8000_0000);
        step("R11", 1, 0, 0, 32'h0000_00A0, 32'h1002, 32'h8000_0000);
        step("R11", 1, 1, 0, 32'h0000_00F0, 32'h1004, 32'h8000_0000);
        // R3 save cycle, with a return strobe that must be ignored (R10)
        step("R10", 0, 0, 1, 32'h1000_0000, 32'h0, 32'h8000_0000);
        // R5 R6 redirect cycle, return strobe again ignored (R10)
        step("R6", 0, 0, 1, 32'h1000_0000, 32'h0, 32'h8000_0000);
        // R7: block bit set, requests ignored
        step("R7", 1, 1, 0, 32'h3000_00F0, 32'h8000_0600, 32'h8000_0000);
        step("R7", 1, 1, 0, 32'h3000_00F0, 32'h8000_0602, 32'h8000_0000);
        // R8: return restores saved values
        step("R8", 0, 1, 1, 32'h3000_00F0, 32'h8000_0610, 32'h8000_0000);
        // R9: return and acceptable request in the same cycle
        step("R9", 1, 1, 1, 32'h0000_0030, 32'h2000, 32'h0);
        step("R9", 0, 0, 0, 32'h0000_0030, 32'h2000, 32'h0);
        // R5: offset wrap at the top of the address space
        step("R5", 1, 1, 0, 32'hC000_0050, 32'h3000, 32'hFFFF_FF00);
        step("R5", 0, 0, 0, 32'h0, 32'h0, 32'hFFFF_FF00);
        step("R5", 0, 0, 0, 32'h0, 32'h0, 32'hFFFF_FF00);
        step("R12", 0, 0, 0, 32'h0, 32'h0, 32'h1234_0000);

        // R2: constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] sr;
            sr = $urandom;
            sr[28] = (($urandom % 10) < 3);
            step("R2", ($urandom % 2) == 0, ($urandom % 2) == 0,
                 ($urandom % 10) == 0, sr, $urandom & 32'hFFFF_FFFE,
                 $urandom & 32'hFFFF_F000);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule